// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A behavioural, synthesizable model of a synchronous pipelined burst memory built from four 9-bit byte lanes. Every control and data input except output enable and the burst-order select is captured on the rising clock edge. A new start address is taken from either of two address strobes. Later words of a burst come from a 2-bit counter that replaces only the two lowest address bits, so every burst stays inside an aligned group of four words and wraps around within it.

Reads pass through one output register, so the data for an access shows up right after the clock edge that took that access. Writes can update any subset of the byte lanes, and a global write input forces all four lanes. Three chip selects must all be active when an address is loaded, or the burst stops. The output-valid flag stands in for the high-impedance state of the data bus and is gated by output enable without a clock. The default depth is 1024 words, which keeps elaboration small. Setting `ADDR_W` to 17 gives the full 131,072-word array.

Top module: `sbs_sram`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output register and the burst state clear. After reset, `rvalid` is 0 until a read happens.
- R2: With `adsp_n` low and `ce_n` low at an edge, the address on `addr` is loaded and read, even if a write is requested. The word shows on `rdata` with `rvalid` high right after that edge. When `ce_n` is high, `adsp_n` is ignored.
- R3: With `adsc_n` low at an edge, and `adsp_n` not loading, `addr` is loaded. The access is a write if a write is requested, and a read if not. A cycle that writes leaves `rvalid` low. When both strobes are low, the `adsp_n` load wins and the cycle reads.
- R4: With `mode` = 0 (linear), each edge with `adv_n` low during an active burst adds 1 modulo 4 to the two lowest address bits. The upper address bits do not change.
- R5: With `mode` = 1 (interleaved), the two lowest address bits of the k-th word are the start bits XOR k, for k = 0, 1, 2, 3, wrapping after the fourth word.
- R6: An edge in an active burst with `adv_n` high and no strobe accesses the same address again.
- R7: With `gw_n` high and `bwe_n` low, bit i of `bw_n` (active low) writes only lane i. Lane 0 is `wdata[8:0]`, lane 1 is `[17:9]`, lane 2 is `[26:18]` and lane 3 is `[35:27]`. With `bwe_n` high and `gw_n` high there is no write, and the cycle reads.
- R8: With `gw_n` low, all four lanes are written, whatever `bwe_n` and `bw_n` are.
- R9: The device is selected only when `ce_n` = 0, `ce2` = 1 and `ce2_n` = 0 at a load edge. A load while unselected makes no access and ends the burst. `rvalid` is 0 right after that edge, and `adv_n` does nothing until the next selected load.
- R10: `rvalid` follows `oe_n` without a clock: it is 0 while `oe_n` is high and returns once `oe_n` is low again.
- R11: A read of an address in the cycle after a write to it returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | External word address |
| adsp_n | input | 1 | Address strobe that always starts a read (active low) |
| adsc_n | input | 1 | Address strobe that starts a read or a write (active low) |
| adv_n | input | 1 | Burst advance (active low) |
| ce_n | input | 1 | Chip enable, active low; also gates `adsp_n` |
| ce2 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write of all lanes (active low) |
| bwe_n | input | 1 | Byte-write qualifier (active low) |
| bw_n | input | 4 | Per-lane write enables (active low) |
| wdata | input | 36 | Write data, four 9-bit lanes |
| oe_n | input | 1 | Output enable, asynchronous (active low) |
| mode | input | 1 | Burst order: 1 interleaved, 0 linear; not registered |
| rdata | output | 36 | Registered read data |
| rvalid | output | 1 | Data-driven flag, stands in for a non-floating bus |

## Verification
The assertions assume that reset is applied for at least one edge before any strobe. They also assume that `mode` does not change in the middle of a burst whose order they reason about. The address and write inputs are taken to be settled at each rising edge. The bench changes every input only just after a rising edge, and holds reset for several cycles first. It keeps `mode` fixed from the start of each burst to its end. It reads back only words it has written earlier in the run.

// File: rtl/sbs_pkg.sv
// Package sbs_pkg
// Shared lane geometry, access kinds and the burst-order function of the
// pipelined burst SRAM. Assumes a burst counter exactly two bits wide.
package sbs_pkg;

    localparam int unsigned LANES  = 4;
    localparam int unsigned LANE_W = 9;
    localparam int unsigned WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    // Low two address bits of a burst word: XOR order or modulo-4 sum.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       ilv);
        return ilv ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/sbs_burst_ctr.sv
// Module sbs_burst_ctr
// Holds the loaded start address and a 2-bit burst step. The address of
// the current access is formed from the next-state values. A load or an
// advance therefore takes effect for the access at the same edge.
// Assumes load and adv are never high together. The top guarantees this.
module sbs_burst_ctr #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] acc_addr
);
    import sbs_pkg::*;

    localparam int unsigned HI_W = ADDR_W - 2;

    logic [HI_W-1:0] hi_q,    hi_d;
    logic [1:0]      start_q, start_d;
    logic [1:0]      step_q,  step_d;

    // Next-state selection: a load restarts, an advance steps, otherwise hold.
    always_comb begin
        hi_d    = hi_q;
        start_d = start_q;
        step_d  = step_q;
        if (load) begin
            hi_d    = ld_addr[ADDR_W-1:2];
            start_d = ld_addr[1:0];
            step_d  = 2'd0;
        end else if (adv) begin
            step_d  = step_q + 2'd1;
        end
    end

    // Address used by this cycle's access.
    assign acc_addr = {hi_d, burst_low(start_d, step_d, ilv)};

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= 2'd0;
            step_q  <= 2'd0;
        end else begin
            hi_q    <= hi_d;
            start_q <= start_d;
            step_q  <= step_d;
        end
    end

    // R4: advancing never disturbs the upper address bits.
    p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (hi_q == $past(hi_q)));

    // R5: the fourth advance wraps the step back to the start word.
    p_step_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && step_q == 2'd3) |=> (step_q == 2'd0));

endmodule

// File: rtl/sbs_lane_mem.sv
// Module sbs_lane_mem
// Storage split into independent byte lanes, one array per lane, each
// with its own write enable. The read is combinational at the same
// address. Assumes the caller registers the read data.
module sbs_lane_mem #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                     clk,
    input  logic [LANES-1:0]         we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata
);
    localparam int unsigned DEPTH = 2 ** ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Lane write on its own enable.
        always_ff @(posedge clk) begin
            if (we[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/sbs_sram.sv
// Module sbs_sram
// Top of the pipelined burst SRAM. It decodes the two address strobes,
// the chip selects and the write controls into one access per clock. It
// drives the burst counter and the lane memory, and registers read data
// in one output stage. Output enable gates the valid flag without a clock.
// Assumes a synchronous active-low reset before the first strobe.
module sbs_sram #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = sbs_pkg::LANES,
    parameter int unsigned LANE_W = sbs_pkg::LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    ce_n,
    input  logic                    ce2,
    input  logic                    ce2_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    input  logic                    mode,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    import sbs_pkg::*;

    localparam int unsigned W_W = LANES * LANE_W;

    logic              sel, wr_req, ld_p, ld_c, load, adv, go;
    logic              burst_q, q_v;
    logic [LANES-1:0]  lane_mask, lane_we;
    logic [ADDR_W-1:0] acc_addr;
    logic [W_W-1:0]    mem_rd, q_d;
    acc_kind_t         kind;

    // Strobe, select and write-request decode for this edge.
    always_comb begin
        sel       = !ce_n && ce2 && !ce2_n;
        wr_req    = !gw_n || (!bwe_n && (bw_n != '1));
        lane_mask = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
        ld_p      = !adsp_n && !ce_n;
        ld_c      = !adsc_n && !ld_p;
        load      = ld_p || ld_c;
        adv       = !load && burst_q && !adv_n;
        go        = load ? sel : burst_q;
    end

    // Access kind: a processor-strobe load always reads.
    always_comb begin
        if (!go)         kind = ACC_NONE;
        else if (ld_p)   kind = ACC_READ;
        else if (wr_req) kind = ACC_WRITE;
        else             kind = ACC_READ;
        lane_we = (kind == ACC_WRITE) ? lane_mask : '0;
    end

    sbs_burst_ctr #(.ADDR_W(ADDR_W)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .ilv      (mode),
        .ld_addr  (addr),
        .acc_addr (acc_addr)
    );

    sbs_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_mem (
        .clk   (clk),
        .we    (lane_we),
        .addr  (acc_addr),
        .wdata (wdata),
        .rdata (mem_rd)
    );

    // Burst-active flag: set by a selected load, cleared by an unselected one.
    always_ff @(posedge clk) begin
        if (!rst_n)    burst_q <= 1'b0;
        else if (load) burst_q <= sel;
    end

    // Output pipeline stage: captures read data and its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_v <= 1'b0;
            q_d <= '0;
        end else begin
            q_v <= (kind == ACC_READ);
            if (kind == ACC_READ) q_d <= mem_rd;
        end
    end

    assign rdata  = q_d;
    assign rvalid = q_v && !oe_n;

    // R2: a processor-strobe load while selected yields valid data next.
    p_adsp_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce_n && ce2 && !ce2_n) |=> q_v);

    // R3: a write cycle puts nothing in the output stage.
    p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0) |=> !q_v);

    // R9: an unselected load makes no access.
    p_desel_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !sel) |=> !q_v);

    // R9: with no burst active and no load, nothing is read.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_q && !load) |=> !q_v);

endmodule

// File: tb/test_sbs_sram.sv
module test_sbs_sram;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic          ce_n = 1'b0, ce2 = 1'b1, ce2_n = 1'b0;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic [35:0]   wdata = '0;
    logic          oe_n = 1'b0, mode = 1'b0;
    logic [35:0]   rdata;
    logic          rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sbs_sram #(.ADDR_W(AW)) i_sbs_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n),
        .adsc_n(adsc_n), .adv_n(adv_n), .ce_n(ce_n), .ce2(ce2),
        .ce2_n(ce2_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .wdata(wdata), .oe_n(oe_n), .mode(mode), .rdata(rdata),
        .rvalid(rvalid)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        ce_n = 1'b0; ce2 = 1'b1; ce2_n = 1'b0;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF;
    endtask

    task automatic chk(input string req, input logic [35:0] act,
                       input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [35:0] exp);
        chk({req, " valid"}, {35'd0, rvalid}, 36'd1);
        chk({req, " data"}, rdata, exp);
    endtask

    task automatic wr_start(input logic [AW-1:0] a, input logic [35:0] d);
        addr = a; adsc_n = 1'b0; gw_n = 1'b0; wdata = d;
        tick(); idle();
    endtask

    task automatic wr_next(input logic [35:0] d);
        adv_n = 1'b0; gw_n = 1'b0; wdata = d;
        tick(); idle();
    endtask

    task automatic rd_start(input logic [AW-1:0] a);
        addr = a; adsp_n = 1'b0;
        tick(); idle();
    endtask

    task automatic rd_next();
        adv_n = 1'b0;
        tick(); idle();
    endtask

    // R1: nothing valid after reset.
    task automatic t_reset();
        chk("R1 reset valid", {35'd0, rvalid}, 36'd0);
    endtask

    // R4, R2, R3: linear write burst from 0x12, then reads.
    task automatic t_linear();
        mode = 1'b0;
        wr_start(10'h012, 36'hA00000000);
        chk("R3 write leaves valid low", {35'd0, rvalid}, 36'd0);
        wr_next(36'hA00000001);
        wr_next(36'hA00000002);
        wr_next(36'hA00000003);
        rd_start(10'h010); chk_rd("R2 R4 linear word 0x10", 36'hA00000002);
        rd_start(10'h011); chk_rd("R4 linear word 0x11", 36'hA00000003);
        rd_start(10'h012); chk_rd("R4 burst start 0x12", 36'hA00000000);
        rd_next();         chk_rd("R4 linear step 1", 36'hA00000001);
        rd_next();         chk_rd("R4 linear wrap", 36'hA00000002);
        rd_next();         chk_rd("R4 linear step 3", 36'hA00000003);
    endtask

    // R5: interleaved burst from low bits 01.
    task automatic t_interleave();
        mode = 1'b1;
        wr_start(10'h021, 36'hB00000000);
        wr_next(36'hB00000001);
        wr_next(36'hB00000002);
        wr_next(36'hB00000003);
        mode = 1'b0;
        rd_start(10'h020); chk_rd("R5 interleave second word at 0x20", 36'hB00000001);
        rd_start(10'h022); chk_rd("R5 interleave fourth word at 0x22", 36'hB00000003);
        mode = 1'b1;
        rd_start(10'h021); chk_rd("R5 interleave start", 36'hB00000000);
        rd_next();         chk_rd("R5 interleave k1", 36'hB00000001);
        rd_next();         chk_rd("R5 interleave k2", 36'hB00000002);
        rd_next();         chk_rd("R5 interleave k3", 36'hB00000003);
        mode = 1'b0;
    endtask

    // R6: a suspend cycle repeats the address, then the burst resumes.
    task automatic t_suspend();
        rd_start(10'h012);
        tick();
        chk_rd("R6 suspend holds address", 36'hA00000000);
        rd_next();
        chk_rd("R6 resume after suspend", 36'hA00000001);
    endtask

    // R7, R8, R11: byte lanes, no-write reads and global write.
    task automatic t_bytes();
        wr_start(10'h030, 36'h0);
        addr = 10'h030; adsc_n = 1'b0; bwe_n = 1'b0; bw_n = 4'b1010;
        wdata = '1;
        tick(); idle();
        addr = 10'h030; adsc_n = 1'b0; bwe_n = 1'b1; bw_n = 4'b0000;
        wdata = 36'h0;
        tick(); idle();
        chk_rd("R7 R11 lanes 0 and 2 only", {9'h0, 9'h1FF, 9'h0, 9'h1FF});
        rd_start(10'h030);
        chk_rd("R7 bwe_n high wrote nothing", {9'h0, 9'h1FF, 9'h0, 9'h1FF});
        addr = 10'h030; adsc_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b1;
        bw_n = 4'hF; wdata = 36'h123456789;
        tick(); idle();
        rd_start(10'h030);
        chk_rd("R8 R11 global write all lanes", 36'h123456789);
    endtask

    // R3, R2: strobe priority and processor strobe ignored with ce_n high.
    task automatic t_priority();
        wr_start(10'h040, 36'hC0FFEE000);
        addr = 10'h040; adsp_n = 1'b0; adsc_n = 1'b0; gw_n = 1'b0;
        wdata = 36'h0DEAD0000;
        tick(); idle();
        chk_rd("R3 both strobes read old word", 36'hC0FFEE000);
        rd_start(10'h040);
        chk_rd("R3 priority cycle did not write", 36'hC0FFEE000);
        rd_start(10'h012);
        addr = 10'h040; adsp_n = 1'b0; ce_n = 1'b1;
        tick(); idle();
        chk_rd("R2 adsp ignored with ce_n high", 36'hA00000000);
    endtask

    // R9: deselection by ce2 or ce2_n at a load.
    task automatic t_deselect();
        rd_start(10'h012);
        addr = 10'h013; adsc_n = 1'b0; ce2 = 1'b0;
        tick(); idle();
        chk("R9 ce2 low deselects", {35'd0, rvalid}, 36'd0);
        rd_next();
        chk("R9 advance ignored after deselect", {35'd0, rvalid}, 36'd0);
        addr = 10'h013; adsp_n = 1'b0; ce2_n = 1'b1;
        tick(); idle();
        chk("R9 ce2_n high deselects", {35'd0, rvalid}, 36'd0);
    endtask

    // R10: output enable gates the valid flag without a clock.
    task automatic t_oe();
        rd_start(10'h011);
        oe_n = 1'b1; #1;
        chk("R10 oe_n high floats output", {35'd0, rvalid}, 36'd0);
        oe_n = 1'b0; #1;
        chk_rd("R10 oe_n low drives output", 36'hA00000003);
    endtask

    initial begin
        idle();
        repeat (4) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_linear();
        t_interleave();
        t_suspend();
        t_bytes();
        t_priority();
        t_deselect();
        t_oe();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule